// File: doc/BRIEF.md
# Byte-Lane Register Bank with Per-Field Write Semantics

This block is a small register bank. A generic request port feeds it: a 32-bit word address, 32-bit write data, separate write-valid and read-valid flags, and four byte enables. A fixed group of registers sits at consecutive word addresses starting from a base address. Each register is split into fields, and each field has its own software write behaviour set by a parameter. The behaviours are plain overwrite, set-on-one, clear-on-one, toggle-on-one, clear-on-zero, toggle-on-zero and clear-on-any-write. An update changes only the byte lanes whose enable is set.

The bank answers every valid request in the same cycle. It returns read data, a ready flag and an error flag. For each field it also drives its current value and two strobes to the surrounding hardware. The access strobe fires on any software touch of the field. The modify strobe fires only on writes. Both strobes count only when a byte enable that covers the field is set.

Top module: `regbank_top`

## Requirements
- R1: While `rst` is high at a clock edge, every field loads its parameterized reset value. The defaults for fields 0..7 are C3C, 3C3, 5A5, A5A, FFF, 000, 123, 0F0 (hex).
- R2: Register k is selected only when `req_addr` equals `BASE_ADDR + k`, for k in 0..N_REGS-1. Any other address selects nothing, and a write to it changes no field.
- R3: Field f of a register occupies register bits [f*FW +: FW]. On a write, each field bit at register position p is updated only when `req_be[p/8]` is set, and it takes its new value from `req_wdata[p]`.
- R4: Mode code 0 (plain) stores the data bit. Code 1 stores old OR data. Code 2 stores old AND NOT data. Code 3 stores old XOR data.
- R5: Code 4 stores old AND data. Code 5 stores old XNOR data. Code 6 stores zero whatever the data. The default mode map for fields 0..7 is 0,1,2,3,4,5,6,0.
- R6: `fld_acc[i]` is high in the cycle of a read or write to field i's register when at least one byte enable of a lane that overlaps the field is set.
- R7: `fld_mod[i]` is high only in the cycle of a write to field i's register with at least one overlapping byte enable set.
- R8: `rsp_rdata` combinationally returns the addressed register's fields as they stood before any write in that cycle. Bits outside all fields read as zero, and an undecoded address reads as zero.
- R9: `rsp_rdy` is high in exactly the cycles where `req_wvld` or `req_rvld` is high. `rsp_err` is high when such a request targets an undecoded address.
- R10: Without `req_wvld`, no field changes. A read leaves all values untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 32 | Word address of the request |
| req_wdata | input | 32 | Write data |
| req_wvld | input | 1 | Write request valid |
| req_rvld | input | 1 | Read request valid |
| req_be | input | 4 | Byte enables, bit n covers data bits [8n+7:8n] |
| rsp_rdata | output | 32 | Read data |
| rsp_rdy | output | 1 | Request accepted this cycle |
| rsp_err | output | 1 | Request hit an undecoded address |
| fld_value | output | FW*N_REGS*FPR (96) | Field values, field i at [i*FW +: FW] |
| fld_acc | output | N_REGS*FPR (8) | Per-field software access strobe |
| fld_mod | output | N_REGS*FPR (8) | Per-field software modify strobe |

## Verification
Each register is written with every one of the 16 byte-enable combinations under four data patterns, and the bank is reset before each pattern.
- The all-zero and all-one patterns separate the one-sensitive modes from the zero-sensitive ones.
- The two mixed patterns, each varied per byte enable, separate OR from XOR and AND from XNOR.
- The fields straddle byte lanes, so a wrong lane-to-bit mapping or a wrong coverage mask shows up in both the values and the strobes.

Reads run alongside half of the writes, which checks that read data shows the pre-write values. Read-only passes and writes to addresses just below and just above the decoded range show that nothing changes outside a decoded write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    WM_PLAIN  = 3'd0,
    WM_SET1   = 3'd1,
    WM_CLR1   = 3'd2,
    WM_TOG1   = 3'd3,
    WM_CLR0   = 3'd4,
    WM_TOG0   = 3'd5,
    WM_CLRANY = 3'd6
  } wmode_e;

  // Next value of one field bit under a given write mode
  function automatic logic wmode_bit(logic [2:0] mode, logic cur, logic din);
    case (mode)
      WM_SET1:   return cur | din;
      WM_CLR1:   return cur & ~din;
      WM_TOG1:   return cur ^ din;
      WM_CLR0:   return cur & din;
      WM_TOG0:   return ~(cur ^ din);
      WM_CLRANY: return 1'b0;
      default:   return din;
    endcase
  endfunction

  // Byte lanes overlapped by bits [pos +: w]
  function automatic logic [LANES-1:0] lane_mask(int pos, int w);
    logic [LANES-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++)
      if ((l * 8 < pos + w) && (l * 8 + 8 > pos)) m[l] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int          N_REGS = 4,
  parameter logic [31:0] BASE   = 32'h10
) (
  input  logic [31:0]       addr,
  input  logic              wvld,
  input  logic              rvld,
  output logic [N_REGS-1:0] sel,
  output logic [N_REGS-1:0] sw_wr,
  output logic [N_REGS-1:0] sw_rd,
  output logic              hit
);
  for (genvar k = 0; k < N_REGS; k++) begin : g_sel
    assign sel[k]   = (addr == BASE + 32'(k));
    assign sw_wr[k] = sel[k] & wvld;
    assign sw_rd[k] = sel[k] & rvld;
  end
  assign hit = |sel;
endmodule

// File: rtl/regbank_field.sv
module regbank_field
  import regbank_pkg::*;
#(
  parameter int          FW      = 12,
  parameter logic [2:0]  MODE    = 3'd0,
  parameter logic [FW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic [FW-1:0] wd,
  input  logic [FW-1:0] bit_en,
  input  logic          lane_hit,
  output logic [FW-1:0] value,
  output logic          acc,
  output logic          mod
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= RST_VAL;
    end else if (sw_wr) begin
      for (int b = 0; b < FW; b++)
        if (bit_en[b]) value[b] <= wmode_bit(MODE, value[b], wd[b]);
    end
  end

  assign acc = (sw_wr | sw_rd) & lane_hit;
  assign mod = sw_wr & lane_hit;
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int N_REGS = 4,
  parameter int DW     = 32
) (
  input  logic [N_REGS*DW-1:0] words,
  input  logic [N_REGS-1:0]    sel,
  output logic [DW-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_REGS; k++)
      if (sel[k]) rdata = rdata | words[k*DW +: DW];
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int          N_REGS    = 4,
  parameter int          FPR       = 2,
  parameter int          FW        = 12,
  parameter logic [31:0] BASE_ADDR = 32'h10,
  parameter logic [3*N_REGS*FPR-1:0] FIELD_MODE =
    {3'd0, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [FW*N_REGS*FPR-1:0] FIELD_RST =
    {12'h0F0, 12'h123, 12'h000, 12'hFFF, 12'hA5A, 12'h5A5, 12'h3C3, 12'hC3C}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [31:0]              req_addr,
  input  logic [31:0]              req_wdata,
  input  logic                     req_wvld,
  input  logic                     req_rvld,
  input  logic [3:0]               req_be,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_rdy,
  output logic                     rsp_err,
  output logic [FW*N_REGS*FPR-1:0] fld_value,
  output logic [N_REGS*FPR-1:0]    fld_acc,
  output logic [N_REGS*FPR-1:0]    fld_mod
);
  localparam int COVER = FPR * FW;

  logic [N_REGS-1:0]        sel, sw_wr, sw_rd;
  logic                     hit;
  logic [N_REGS*DATA_W-1:0] words;
  logic                     unused_wdata_bits;

  assign unused_wdata_bits = ^req_wdata;

  regbank_decode #(.N_REGS(N_REGS), .BASE(BASE_ADDR)) u_decode (
    .addr(req_addr), .wvld(req_wvld), .rvld(req_rvld),
    .sel(sel), .sw_wr(sw_wr), .sw_rd(sw_rd), .hit(hit)
  );

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] word;
    for (genvar f = 0; f < FPR; f++) begin : g_fld
      localparam int I   = k * FPR + f;
      localparam int POS = f * FW;
      localparam logic [LANES-1:0] LMASK = lane_mask(POS, FW);
      logic [FW-1:0] ben;
      logic [FW-1:0] val;
      for (genvar b = 0; b < FW; b++) begin : g_ben
        assign ben[b] = req_be[(POS + b) / 8];
      end
      regbank_field #(
        .FW(FW), .MODE(FIELD_MODE[3*I +: 3]), .RST_VAL(FIELD_RST[FW*I +: FW])
      ) u_field (
        .clk(clk), .rst(rst), .sw_wr(sw_wr[k]), .sw_rd(sw_rd[k]),
        .wd(req_wdata[POS +: FW]), .bit_en(ben),
        .lane_hit(|(req_be & LMASK)),
        .value(val), .acc(fld_acc[I]), .mod(fld_mod[I])
      );
      assign word[POS +: FW]       = val;
      assign fld_value[FW*I +: FW] = val;
    end
    if (COVER < DATA_W) begin : g_pad
      assign word[DATA_W-1:COVER] = '0;
    end
    assign words[k*DATA_W +: DATA_W] = word;
  end

  regbank_rdmux #(.N_REGS(N_REGS), .DW(DATA_W)) u_rdmux (
    .words(words), .sel(sel), .rdata(rsp_rdata)
  );

  assign rsp_rdy = req_wvld | req_rvld;
  assign rsp_err = rsp_rdy & ~hit;
endmodule

// File: rtl/regbank_sva.sv
module regbank_sva #(
  parameter int N_REGS = 4,
  parameter int FPR    = 2,
  parameter int FW     = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_wvld,
  input logic                     rsp_rdy,
  input logic                     rsp_err,
  input logic [31:0]              rsp_rdata,
  input logic [FW*N_REGS*FPR-1:0] fld_value,
  input logic [N_REGS*FPR-1:0]    fld_acc,
  input logic [N_REGS*FPR-1:0]    fld_mod
);
  localparam int COVER = FPR * FW;
  localparam logic [31:0] COV_MASK =
    (COVER >= 32) ? 32'hFFFF_FFFF : ((32'd1 << COVER) - 32'd1);

  p_err_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdy);
  p_acc_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    (|fld_acc) |-> rsp_rdy);
  p_mod_within_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (fld_mod & ~fld_acc) == '0);
  p_mod_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
    (|fld_mod) |-> req_wvld);
  p_undecoded_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (fld_acc == '0));
  p_undecoded_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
  p_uncovered_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_rdata & ~COV_MASK) == '0);
  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !req_wvld |=> $stable(fld_value));
endmodule

bind regbank_top regbank_sva #(.N_REGS(N_REGS), .FPR(FPR), .FW(FW)) u_sva (
  .clk(clk), .rst(rst), .req_wvld(req_wvld), .rsp_rdy(rsp_rdy),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .fld_value(fld_value),
  .fld_acc(fld_acc), .fld_mod(fld_mod)
);

// File: tb/regbank_top_bench.sv
module regbank_top_bench;
  localparam int CLK_P  = 10;
  localparam int N_REGS = 4;
  localparam int FPR    = 2;
  localparam int FW     = 12;
  localparam int NF     = N_REGS * FPR;
  localparam logic [31:0] BASE = 32'h10;
  localparam logic [2:0]    MODES [NF] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd0};
  localparam logic [FW-1:0] RSTV  [NF] = '{12'hC3C, 12'h3C3, 12'h5A5, 12'hA5A,
                                           12'hFFF, 12'h000, 12'h123, 12'h0F0};
  localparam logic [31:0]   PATS  [4]  = '{32'h0000_0000, 32'hFFFF_FFFF,
                                           32'h1234_5678, 32'hA5C3_3C5A};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_wvld = 1'b0, req_rvld = 1'b0;
  logic [3:0] req_be = '0;
  logic [31:0] rsp_rdata;
  logic rsp_rdy, rsp_err;
  logic [FW*NF-1:0] fld_value;
  logic [NF-1:0] fld_acc, fld_mod;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [FW-1:0] model [NF];

  always #(CLK_P/2) clk = ~clk;

  regbank_top u_regbank_top (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wvld(req_wvld), .req_rvld(req_rvld), .req_be(req_be),
    .rsp_rdata(rsp_rdata), .rsp_rdy(rsp_rdy), .rsp_err(rsp_err),
    .fld_value(fld_value), .fld_acc(fld_acc), .fld_mod(fld_mod)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(logic [2:0] m, logic c, logic d);
    case (m)
      3'd1: return c | d;
      3'd2: return c & ~d;
      3'd3: return c ^ d;
      3'd4: return c & d;
      3'd5: return ~(c ^ d);
      3'd6: return 1'b0;
      default: return d;
    endcase
  endfunction

  function automatic logic [3:0] lmask(int pos);
    logic [3:0] m = '0;
    for (int b = 0; b < FW; b++) m[(pos + b) / 8] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] model_word(int k);
    logic [31:0] w = '0;
    for (int f = 0; f < FPR; f++) w[f*FW +: FW] = model[k*FPR + f];
    return w;
  endfunction

  task automatic check_fields(string tag);
    for (int i = 0; i < NF; i++)
      chk(tag, 32'(fld_value[i*FW +: FW]), 32'(model[i]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_wvld = 1'b0; req_rvld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NF; i++) model[i] = RSTV[i];
    check_fields("R1 reset value");
  endtask

  task automatic op(logic [31:0] a, logic [31:0] wd, logic wv, logic rv, logic [3:0] be);
    bit hit;
    int k;
    logic [NF-1:0] e_acc, e_mod;
    @(negedge clk);
    req_addr = a; req_wdata = wd; req_wvld = wv; req_rvld = rv; req_be = be;
    #1;
    hit = (a >= BASE) && (a < BASE + N_REGS);
    k = hit ? int'(a - BASE) : 0;
    chk("R8 read data", rsp_rdata, hit ? model_word(k) : 32'h0);
    chk("R9 ready", 32'(rsp_rdy), 32'(wv | rv));
    chk("R9 error", 32'(rsp_err), 32'((wv | rv) & !hit));
    e_acc = '0; e_mod = '0;
    for (int i = 0; i < NF; i++) begin
      if (hit && (i / FPR == k) && |(be & lmask((i % FPR) * FW))) begin
        e_acc[i] = wv | rv;
        e_mod[i] = wv;
      end
    end
    chk("R6 access strobe", 32'(fld_acc), 32'(e_acc));
    chk("R7 modify strobe", 32'(fld_mod), 32'(e_mod));
    if (hit && wv) begin
      for (int f = 0; f < FPR; f++) begin
        int i = k * FPR + f;
        for (int b = 0; b < FW; b++) begin
          int p = f * FW + b;
          if (be[p / 8]) model[i][b] = exp_bit(MODES[i], model[i][b], wd[p]);
        end
      end
    end
    @(posedge clk);
    #1;
    check_fields("R2 R3 R4 R5 R10 field value");
  endtask

  initial begin
    do_reset();
    op(BASE, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'hF);  // R9 idle, R10 no write
    for (int p = 0; p < 4; p++) begin
      do_reset();
      for (int k = 0; k < N_REGS; k++)
        for (int be = 0; be < 16; be++)
          op(BASE + 32'(k), PATS[p] ^ (32'(be) * 32'h1111_1111), 1'b1,
             1'(be & 1), 4'(be));
      for (int k = 0; k < N_REGS; k++)
        op(BASE + 32'(k), 32'hFFFF_FFFF, 1'b0, 1'b1, 4'hF);  // R10 read only
    end
    // R2 undecoded addresses around and away from the decoded range
    op(BASE - 32'd1, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'hF);
    op(BASE + N_REGS, 32'h0000_0000, 1'b1, 1'b1, 4'hF);
    op(32'h0000_0000, 32'h5555_5555, 1'b1, 1'b0, 4'hF);
    op(32'hFFFF_FFFF, 32'hAAAA_AAAA, 1'b0, 1'b1, 4'hF);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule